// File: doc/BRIEF.md
# Format-Track Byte Stream Parser

This block sits behind the data port of a floppy disk controller while a whole-track command is running. During a write-track (format) command the host pushes the complete raw image of a track one byte at a time. The block counts those bytes against the length that a formatted track of the current density occupies, keeps the data request flag raised while more bytes are wanted, and ends the command with an interrupt request once the track is full. During a read-track command it applies the same accounting to host reads of the data port.

While formatting, the block also picks the sector payloads out of the stream. A data mark byte (0xFB) seen outside a payload opens a 128-byte capture window. The mark itself is counted but not stored, and the bytes that follow fill a local sector buffer. When the window closes, the block offers the buffer to the media side through a valid/ready commit port that carries the track number and the sector number. The media side answers with a success flag, which sets or clears the write fault flag. The sector number then steps forward, but it never passes the number of sectors the current track holds.

The track length is 73 + 247 bytes of fixed overhead plus the sector fields: 26 fields of 186 bytes in single density (5156 bytes) and 51 fields of 196 bytes in double density (10316 bytes). Track 0 on side 0 always holds 26 sectors, whatever the density.

Top module: `fmt_stream_parser`

## Requirements
- R1: After reset busy, drq, intrq, wr_fault and cmt_valid are 0 and sector_reg is 1.
- R2: A pulse on cmd_wr_trk or cmd_rd_trk sets busy=1, drq=1 (0 if a commit is still outstanding) and intrq=0 on the next cycle, and clears the byte count, the capture count and capture mode.
- R3: During write-track every accepted host_wr byte adds one to the count. Before the count reaches the track length (5156 when dbl_den=0, 10316 when dbl_den=1), drq is 1. On the cycle after the byte that makes the count equal the length, busy=0, drq=0, wr_fault=0 and intrq=1.
- R4: A written 0xFB while no capture is open arms capture without being stored. The next 128 accepted bytes are stored at buffer addresses 0 to 127 in arrival order and can be read back through buf_addr/buf_data.
- R5: On the cycle after the 128th captured byte, cmt_valid=1, cmt_track equals track_no, cmt_sector equals sector_reg, drq=0 and wr_fault=0. While cmt_valid is 1, host bytes are neither counted nor stored.
- R6: One cycle after cmt_valid and cmt_ready are both 1, cmt_valid=0 and wr_fault equals the inverse of cmt_ok. drq returns to 1 if the track command is still running. Until the handshake, cmt_valid, cmt_track and cmt_sector hold.
- R7: After each commit, sector_reg increments only if it is below the sector limit. The limit is 26 when dbl_den=0, or when track_no=0 and side_sel=0; otherwise it is 51.
- R8: During read-track each host_rd pulse adds one to the count while the count is below the track length. The read that finds the count equal to the length ends the command: busy=0, drq=0, intrq=1. This is read number length+1 after the start.
- R9: host_wr outside write-track and host_rd outside read-track change no flag and no count. A 0xFB received inside an open capture window is stored as data.
- R10: A pulse on sec_load loads sec_load_val into sector_reg. Otherwise sector_reg changes only on a commit.
- R11: Restarting write-track part way through a track discards the partial count and any open capture. A full track length of bytes is then needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbl_den | input | 1 | Double density selected for the current drive |
| side_sel | input | 1 | Head side in use |
| track_no | input | 8 | Current track register value |
| cmd_wr_trk | input | 1 | One-cycle pulse: start write-track |
| cmd_rd_trk | input | 1 | One-cycle pulse: start read-track |
| sec_load | input | 1 | Host write strobe of the sector register |
| sec_load_val | input | 8 | Value for the sector register |
| host_wr | input | 1 | Host data-port write strobe |
| host_wdata | input | 8 | Host data-port write byte |
| host_rd | input | 1 | Host data-port read strobe |
| drq | output | 1 | Data request |
| intrq | output | 1 | Command complete interrupt request |
| busy | output | 1 | Track command in progress |
| wr_fault | output | 1 | Last sector commit failed |
| sector_reg | output | 8 | Sector register |
| cmt_valid | output | 1 | Sector commit offered |
| cmt_ready | input | 1 | Media side accepts the commit |
| cmt_ok | input | 1 | Commit succeeded, sampled with cmt_ready |
| cmt_track | output | 8 | Track of the committed sector |
| cmt_sector | output | 8 | Sector number of the committed sector |
| buf_addr | input | 7 | Sector buffer read address |
| buf_data | output | 8 | Sector buffer read data |

## Verification
The hardest case to reach is a track whose commits and boundaries interact. Several capture windows must open and close within one stream of 5156 or 10316 bytes, a commit must fail partway through and a later one succeed, and the sector number must stop at its limit on track 0 side 0 in double density. The host must also try to push bytes while a commit is still outstanding. The bench streams random filler with the marks placed at planned offsets and random payloads containing a stray 0xFB. It holds cmt_ready off for a random number of cycles and slips in a rejected write during that wait. A miscount of even one byte shows up at the exact cycle where the track should end. A restart in the middle of an open capture window checks that no stale payload survives it.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_WRTRK = 2'd1,
    MODE_RDTRK = 2'd2
  } fmt_mode_e;

  // Bytes in one formatted track: fixed overhead plus one field per sector.
  function automatic int unsigned trk_bytes(input logic dd, input int unsigned ovh,
                                            input int unsigned sd_n, input int unsigned sd_f,
                                            input int unsigned dd_n, input int unsigned dd_f);
    return ovh + (dd ? dd_n * dd_f : sd_n * sd_f);
  endfunction

  // Sector count of a track; track 0 of side 0 stays single density.
  function automatic int unsigned sec_limit(input logic dd, input logic side,
                                            input logic trk_zero,
                                            input int unsigned sd_n, input int unsigned dd_n);
    return (dd && (side || !trk_zero)) ? dd_n : sd_n;
  endfunction

endpackage

// File: rtl/fmt_trk_counter.sv
module fmt_trk_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic [CNT_W-1:0] len,
  output logic             at_len,
  output logic             at_last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (inc)   cnt <= cnt + CNT_W'(1);
  end

  assign at_len  = (cnt == len);
  assign at_last = (cnt == len - CNT_W'(1));
endmodule

// File: rtl/fmt_sec_capture.sv
module fmt_sec_capture #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SEC_BYTES = 128,
  parameter int unsigned CAP_W     = 7,
  parameter int unsigned TRK_W     = 8,
  parameter int unsigned SEC_W     = 8,
  parameter logic [DATA_W-1:0] MARK_BYTE = 8'hFB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              byte_ok,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [TRK_W-1:0]  trk_in,
  input  logic [SEC_W-1:0]  sec_in,
  input  logic              cmt_ready,
  input  logic [CAP_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              capturing,
  output logic              mark_ev,
  output logic              last_ev,
  output logic              cmt_fire,
  output logic              cmt_valid,
  output logic [TRK_W-1:0]  cmt_track,
  output logic [SEC_W-1:0]  cmt_sector
);
  logic [CAP_W-1:0]  cap_cnt;
  logic [DATA_W-1:0] mem [SEC_BYTES];
  logic              cap_byte;

  assign mark_ev  = byte_ok && !capturing && (byte_in == MARK_BYTE);
  assign cap_byte = byte_ok && capturing;
  assign last_ev  = cap_byte && (cap_cnt == CAP_W'(SEC_BYTES - 1));
  assign cmt_fire = cmt_valid && cmt_ready;
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (cap_byte) mem[cap_cnt] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capturing <= 1'b0;
      cap_cnt   <= '0;
    end else if (clear) begin
      capturing <= 1'b0;
      cap_cnt   <= '0;
    end else if (mark_ev) begin
      capturing <= 1'b1;
      cap_cnt   <= '0;
    end else if (last_ev) begin
      capturing <= 1'b0;
      cap_cnt   <= '0;
    end else if (cap_byte) begin
      cap_cnt   <= cap_cnt + CAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmt_valid  <= 1'b0;
      cmt_track  <= '0;
      cmt_sector <= '0;
    end else if (last_ev) begin
      cmt_valid  <= 1'b1;
      cmt_track  <= trk_in;
      cmt_sector <= sec_in;
    end else if (cmt_fire) begin
      cmt_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/fmt_sec_stepper.sv
module fmt_sec_stepper #(
  parameter int unsigned SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  input  logic             advance,
  input  logic [SEC_W-1:0] limit,
  output logic [SEC_W-1:0] sec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      sec <= SEC_W'(1);
    else if (load)                   sec <= load_val;
    else if (advance && sec < limit) sec <= sec + SEC_W'(1);
  end
endmodule

// File: rtl/fmt_stream_parser.sv
module fmt_stream_parser
  import fmt_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 73,
  parameter int unsigned GAP_BYTES = 247,
  parameter int unsigned SD_SECS   = 26,
  parameter int unsigned SD_FIELD  = 186,
  parameter int unsigned DD_SECS   = 51,
  parameter int unsigned DD_FIELD  = 196,
  parameter int unsigned SEC_BYTES = 128,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TRK_W     = 8,
  parameter int unsigned SEC_W     = 8,
  parameter logic [DATA_W-1:0] MARK_BYTE = 8'hFB,
  localparam int unsigned CAP_W    = $clog2(SEC_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbl_den,
  input  logic              side_sel,
  input  logic [TRK_W-1:0]  track_no,
  input  logic              cmd_wr_trk,
  input  logic              cmd_rd_trk,
  input  logic              sec_load,
  input  logic [SEC_W-1:0]  sec_load_val,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic              drq,
  output logic              intrq,
  output logic              busy,
  output logic              wr_fault,
  output logic [SEC_W-1:0]  sector_reg,
  output logic              cmt_valid,
  input  logic              cmt_ready,
  input  logic              cmt_ok,
  output logic [TRK_W-1:0]  cmt_track,
  output logic [SEC_W-1:0]  cmt_sector,
  input  logic [CAP_W-1:0]  buf_addr,
  output logic [DATA_W-1:0] buf_data
);
  localparam int unsigned OVERHEAD = HDR_BYTES + GAP_BYTES;
  localparam int unsigned LEN_SD   = trk_bytes(1'b0, OVERHEAD, SD_SECS, SD_FIELD, DD_SECS, DD_FIELD);
  localparam int unsigned LEN_DD   = trk_bytes(1'b1, OVERHEAD, SD_SECS, SD_FIELD, DD_SECS, DD_FIELD);
  localparam int unsigned MAX_LEN  = (LEN_DD > LEN_SD) ? LEN_DD : LEN_SD;
  localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1);

  fmt_mode_e        mode;
  logic [CNT_W-1:0] trk_len;
  logic [SEC_W-1:0] spt_now;

  // Named internal events
  logic start_any, byte_acc, rd_acc, wr_end, rd_end, cmd_end, cnt_inc;
  logic at_len, at_last;
  logic capturing, mark_ev, last_ev, cmt_fire;

  assign trk_len = dbl_den ? CNT_W'(LEN_DD) : CNT_W'(LEN_SD);
  assign spt_now = SEC_W'(sec_limit(dbl_den, side_sel, track_no == '0, SD_SECS, DD_SECS));

  assign start_any = cmd_wr_trk || cmd_rd_trk;
  assign byte_acc  = (mode == MODE_WRTRK) && host_wr && !cmt_valid && !start_any;
  assign rd_acc    = (mode == MODE_RDTRK) && host_rd && !cmt_valid && !start_any;
  assign wr_end    = byte_acc && at_last;
  assign rd_end    = rd_acc && at_len;
  assign cmd_end   = wr_end || rd_end;
  assign cnt_inc   = byte_acc || (rd_acc && !at_len);

  fmt_trk_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_any),
    .inc     (cnt_inc),
    .len     (trk_len),
    .at_len  (at_len),
    .at_last (at_last)
  );

  fmt_sec_capture #(
    .DATA_W(DATA_W), .SEC_BYTES(SEC_BYTES), .CAP_W(CAP_W),
    .TRK_W(TRK_W), .SEC_W(SEC_W), .MARK_BYTE(MARK_BYTE)
  ) i_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_any),
    .byte_ok    (byte_acc),
    .byte_in    (host_wdata),
    .trk_in     (track_no),
    .sec_in     (sector_reg),
    .cmt_ready  (cmt_ready),
    .rd_addr    (buf_addr),
    .rd_data    (buf_data),
    .capturing  (capturing),
    .mark_ev    (mark_ev),
    .last_ev    (last_ev),
    .cmt_fire   (cmt_fire),
    .cmt_valid  (cmt_valid),
    .cmt_track  (cmt_track),
    .cmt_sector (cmt_sector)
  );

  fmt_sec_stepper #(.SEC_W(SEC_W)) i_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sec_load),
    .load_val (sec_load_val),
    .advance  (cmt_fire),
    .limit    (spt_now),
    .sec      (sector_reg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_IDLE;
      busy     <= 1'b0;
      drq      <= 1'b0;
      intrq    <= 1'b0;
      wr_fault <= 1'b0;
    end else if (start_any) begin
      mode     <= cmd_wr_trk ? MODE_WRTRK : MODE_RDTRK;
      busy     <= 1'b1;
      drq      <= !cmt_valid;
      intrq    <= 1'b0;
      wr_fault <= 1'b0;
    end else begin
      if (cmd_end) begin
        mode     <= MODE_IDLE;
        busy     <= 1'b0;
        drq      <= 1'b0;
        intrq    <= 1'b1;
        wr_fault <= 1'b0;
      end else if (last_ev) begin
        drq      <= 1'b0;
        wr_fault <= 1'b0;
      end else if (byte_acc || rd_acc) begin
        drq      <= 1'b1;
      end
      if (cmt_fire) begin
        wr_fault <= !cmt_ok;
        if (mode != MODE_IDLE && !cmd_end) drq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fmt_stream_checker.sv
module fmt_stream_checker #(
  parameter int unsigned TRK_W = 8,
  parameter int unsigned SEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             drq,
  input logic             intrq,
  input logic             cmt_valid,
  input logic             cmt_ready,
  input logic [TRK_W-1:0] cmt_track,
  input logic [SEC_W-1:0] cmt_sector,
  input logic [SEC_W-1:0] sector_reg,
  input logic             sec_load,
  input logic             cmt_fire,
  input logic [SEC_W-1:0] spt_now,
  input logic             mark_ev,
  input logic             capturing
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !drq);

  assert_done_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    intrq |-> (!busy && !drq));

  assert_mark_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mark_ev |=> capturing);

  assert_commit_no_drq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> !drq);

  assert_commit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !cmt_ready) |=> (cmt_valid && $stable(cmt_track) && $stable(cmt_sector)));

  assert_sector_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_fire && !sec_load && (sector_reg >= spt_now)) |=> $stable(sector_reg));

  assert_sector_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_load && !cmt_fire) |=> $stable(sector_reg));
endmodule

bind fmt_stream_parser fmt_stream_checker #(.TRK_W(TRK_W), .SEC_W(SEC_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .drq        (drq),
  .intrq      (intrq),
  .cmt_valid  (cmt_valid),
  .cmt_ready  (cmt_ready),
  .cmt_track  (cmt_track),
  .cmt_sector (cmt_sector),
  .sector_reg (sector_reg),
  .sec_load   (sec_load),
  .cmt_fire   (cmt_fire),
  .spt_now    (spt_now),
  .mark_ev    (mark_ev),
  .capturing  (capturing)
);

// File: tb/test_fmt_stream_parser.sv
module test_fmt_stream_parser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dbl_den = 1'b0, side_sel = 1'b0;
  logic [7:0] track_no = '0;
  logic       cmd_wr_trk = 1'b0, cmd_rd_trk = 1'b0;
  logic       sec_load = 1'b0;
  logic [7:0] sec_load_val = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       drq, intrq, busy, wr_fault, cmt_valid;
  logic       cmt_ready = 1'b0, cmt_ok = 1'b0;
  logic [7:0] sector_reg, cmt_track, cmt_sector, buf_data;
  logic [6:0] buf_addr = '0;

  int checks = 0;
  int errors = 0;
  int exp_sec = 1;
  logic [7:0] exp_buf [128];

  always #5 clk = ~clk;

  fmt_stream_parser i_fmt_stream_parser (
    .clk(clk), .rst_n(rst_n), .dbl_den(dbl_den), .side_sel(side_sel), .track_no(track_no),
    .cmd_wr_trk(cmd_wr_trk), .cmd_rd_trk(cmd_rd_trk), .sec_load(sec_load),
    .sec_load_val(sec_load_val), .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .drq(drq), .intrq(intrq), .busy(busy), .wr_fault(wr_fault), .sector_reg(sector_reg),
    .cmt_valid(cmt_valid), .cmt_ready(cmt_ready), .cmt_ok(cmt_ok), .cmt_track(cmt_track),
    .cmt_sector(cmt_sector), .buf_addr(buf_addr), .buf_data(buf_data)
  );

  function automatic int exp_len(input logic dd);
    return dd ? (73 + 247 + 51 * 196) : (73 + 247 + 26 * 186);
  endfunction

  function automatic int exp_spt(input logic dd, input logic sd, input logic [7:0] trk);
    if (!dd) return 26;
    if (trk == 8'd0 && !sd) return 26;
    return 51;
  endfunction

  function automatic logic [7:0] filler();
    logic [7:0] v;
    v = 8'($urandom);
    return (v == 8'hFB) ? 8'h4E : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] b);
    host_wr = 1'b1; host_wdata = b;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic rd_pulse();
    host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
  endtask

  task automatic load_sector(input int v);
    sec_load = 1'b1; sec_load_val = 8'(v);
    tick();
    sec_load = 1'b0;
    exp_sec = v;
    chk(sector_reg == 8'(v), "R10", sector_reg, v);
  endtask

  task automatic start_cmd(input bit wr);
    if (wr) cmd_wr_trk = 1'b1; else cmd_rd_trk = 1'b1;
    tick();
    cmd_wr_trk = 1'b0; cmd_rd_trk = 1'b0;
    chk({busy, drq, intrq} == 3'b110, "R2", {busy, drq, intrq}, 3'b110);
  endtask

  task automatic do_commit(input logic dd, input logic sd, input logic [7:0] trk, input bit ok);
    int bad;
    chk(cmt_valid && cmt_track == trk && cmt_sector == 8'(exp_sec), "R5",
        {cmt_valid, cmt_track, cmt_sector}, {1'b1, trk, 8'(exp_sec)});
    chk({drq, wr_fault} == 2'b00, "R5", {drq, wr_fault}, 0);
    // A write during the pending commit must be refused.
    wr_byte(8'hFB);
    chk(cmt_valid && !drq, "R5", {cmt_valid, drq}, 2'b10);
    bad = 0;
    for (int a = 0; a < 128; a++) begin
      buf_addr = 7'(a);
      #1;
      if (buf_data !== exp_buf[a]) bad++;
    end
    chk(bad == 0, "R4", bad, 0);
    tick();
    repeat ($urandom % 3) tick();
    cmt_ready = 1'b1; cmt_ok = ok;
    tick();
    cmt_ready = 1'b0;
    if (exp_sec < exp_spt(dd, sd, trk)) exp_sec++;
    chk({cmt_valid, wr_fault, drq} == {1'b0, !ok, 1'b1}, "R6",
        {cmt_valid, wr_fault, drq}, {1'b0, !ok, 1'b1});
    chk(sector_reg == 8'(exp_sec), "R7", sector_reg, exp_sec);
  endtask

  task automatic run_wr(input logic dd, input logic sd, input logic [7:0] trk,
                        input int nmarks, input int pre, input int sec0, input int fail_k);
    int len, cc, marks;
    bit cap;
    logic [7:0] b;
    dbl_den = dd; side_sel = sd; track_no = trk;
    load_sector(sec0);
    if (pre > 0) begin
      start_cmd(1'b1);
      for (int i = 0; i < pre; i++) wr_byte((i == 3) ? 8'hFB : filler());
    end
    start_cmd(1'b1);
    len = exp_len(dd); cc = 0; marks = 0; cap = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (!cap && marks < nmarks && i >= 40 + marks * 400) begin
        b = 8'hFB; cap = 1'b1; cc = 0; marks++;
      end else if (cap) begin
        b = (cc == 5) ? 8'hFB : 8'($urandom);
        exp_buf[cc] = b; cc++;
      end else begin
        b = filler();
      end
      wr_byte(b);
      if (i == len - 1) begin
        chk({intrq, busy, drq, wr_fault} == 4'b1000, "R3", {intrq, busy, drq, wr_fault}, 4'b1000);
      end else if (cap && cc == 128) begin
        cap = 1'b0;
        do_commit(dd, sd, trk, marks != fail_k);
      end else begin
        chk({busy, drq, cmt_valid, intrq} == 4'b1100, (pre > 0) ? "R11" : "R3",
            {busy, drq, cmt_valid, intrq}, 4'b1100);
        if (i == 17) begin
          rd_pulse();
          chk(drq && busy && !intrq, "R9", {busy, drq, intrq}, 3'b110);
        end
      end
    end
  endtask

  task automatic run_rd(input logic dd);
    int len;
    dbl_den = dd;
    start_cmd(1'b0);
    len = exp_len(dd);
    for (int i = 0; i < len; i++) begin
      rd_pulse();
      chk({busy, drq, intrq} == 3'b110, "R8", {busy, drq, intrq}, 3'b110);
      if (i == 10) begin
        wr_byte(8'hFB);
        chk({busy, drq, intrq, cmt_valid} == 4'b1100, "R9", {busy, drq, intrq, cmt_valid}, 4'b1100);
      end
    end
    rd_pulse();
    chk({busy, drq, intrq} == 3'b001, "R8", {busy, drq, intrq}, 3'b001);
  endtask

  initial begin
    #(190000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk({busy, drq, intrq, wr_fault, cmt_valid} == 5'b0 && sector_reg == 8'd1, "R1",
        {busy, drq, intrq, wr_fault, cmt_valid, sector_reg}, 1);
    // Writes and reads while idle are ignored.
    wr_byte(8'hFB);
    rd_pulse();
    chk({busy, drq, intrq, cmt_valid} == 4'b0 && sector_reg == 8'd1, "R9",
        {busy, drq, intrq, cmt_valid}, 0);
    // Single density, one failing commit in the middle.
    run_wr(1'b0, 1'b0, 8'd3, 3, 0, 1, 2);
    // Double density on track 0 side 0: limit 26, sector stops there.
    run_wr(1'b1, 1'b0, 8'd0, 2, 0, 25, 99);
    // Double density side 1 with a restart inside an open window: limit 51.
    run_wr(1'b1, 1'b1, 8'd0, 2, 100, 50, 99);
    run_rd(1'b0);
    run_rd(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule